// File: doc/BRIEF.md
# Leak-Group Linked-List Shaper Walker

This block drives the refill ("leak") events for an array of traffic shapers. The shapers are sorted into a small number of leak groups. Each group has a programmable period in nanoseconds and a head pointer. Each shaper element has a next-link entry. Together the head and the links form a singly linked list per group, and the list ends at an element whose link points back to itself. When the period of a group elapses, the walker follows that group's list from the head. It emits one registered leak pulse per clock, and each pulse carries the element index and the group number.

Software programs the block through a single write port. A write of kind 0 sets the period of group `wr_addr`. A write of kind 1 sets the head of group `wr_addr`. A write of kind 2 sets the link of element `wr_addr`. Data always comes from the low bits of `wr_data`. A period of zero stops the group and marks it as empty. To reconfigure a list safely, software first writes period 0, then rewrites the links and the head, then restores the period.

Top module: `leak_walker`

## Requirements
- R1: After reset all periods are zero, and `leak_vld` stays low until a nonzero period is written.
- R2: A group whose period is zero never produces a pulse. Writing zero to a group's period discards any expiry already latched for it.
- R3: Let P be the value written to a period (write kind 0), and N = ceil(P / CLK_NS) with N ≥ 2. The first pulse of that group appears N+2 clocks after the write edge, and the group then expires every N clocks.
- R4: A walk emits one pulse per clock. It starts at the head (write kind 1), follows the links (write kind 2), and ends after the pulse for the element that links to itself. Each pulse carries the group number on `leak_grp`.
- R5: When several groups have latched expiries, they are walked in ascending group order. There is one idle clock between consecutive walks.
- R6: An expiry that arrives while a walk is running is latched and is walked after the current walk ends. No walk is dropped or cut short.
- R7: A period write to the group being walked aborts the walk. No pulse is emitted from the clock edge of that write onward.
- R8: A walk emits at most NUM_ELEMS pulses, even when the links form a cycle with no self-link.
- R9: A one-element group (head linking to itself) emits exactly one pulse per expiry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Configuration write strobe |
| wr_kind | input | 2 | Write kind: 0 period, 1 head, 2 link |
| wr_addr | input | ADDR_W | Group number (period/head) or element index (link) |
| wr_data | input | PERIOD_W | Period in ns, or element index in the low IDX_W bits |
| leak_vld | output | 1 | Leak pulse valid |
| leak_idx | output | IDX_W | Element index of the pulse |
| leak_grp | output | GRP_W | Group number of the pulse |

## Verification
The bench builds the block with four groups, eight elements, a 12-bit period and CLK_NS = 4. With this configuration, every list length from one to eight can be walked, and every period from 5 to 40 ns can be swept, so each rounding case of the ceiling division is exercised. Short periods against an eight-element list bring the overrun latch within reach. Staggered period writes bring a simultaneous expiry of all four groups within reach. A two-element loop reaches the walk-length bound.

// File: rtl/lw_pkg.sv
package lw_pkg;
  typedef enum logic [1:0] {
    WR_PERIOD = 2'd0,
    WR_HEAD   = 2'd1,
    WR_LINK   = 2'd2
  } wr_kind_e;
endpackage

// File: rtl/lw_timer.sv
// Per-group period counter: accumulates CLK_NS each clock, pulses expire when
// the next step would reach the programmed period in nanoseconds.
module lw_timer #(
  parameter int PERIOD_W = 24,
  parameter int CLK_NS   = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                per_we,
  input  logic [PERIOD_W-1:0] per_val,
  output logic                expire
);
  localparam logic [PERIOD_W:0] STEP = (PERIOD_W+1)'(CLK_NS);

  logic [PERIOD_W-1:0] per_q;
  logic [PERIOD_W-1:0] cnt;

  assign expire = !per_we && (per_q != '0) &&
                  (({1'b0, cnt} + STEP) >= {1'b0, per_q});

  always_ff @(posedge clk) begin
    if (rst) begin
      per_q <= '0;
      cnt   <= '0;
    end else if (per_we) begin
      per_q <= per_val;
      cnt   <= '0;
    end else if (per_q == '0 || expire) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + PERIOD_W'(CLK_NS);
    end
  end

  assert_cnt_below_period_R3: assert property (@(posedge clk) disable iff (rst)
    (per_q != '0) |-> (cnt < per_q));
  assert_zero_period_idle_R2: assert property (@(posedge clk) disable iff (rst)
    (per_q == '0) |=> (cnt == '0));
endmodule

// File: rtl/lw_link_ram.sv
// Next-link table, one entry per element; asynchronous read so the walker
// can advance one element per clock.
module lw_link_ram #(
  parameter int DEPTH = 64,
  parameter int W     = 6
) (
  input  logic         clk,
  input  logic         we,
  input  logic [W-1:0] waddr,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] raddr,
  output logic [W-1:0] rdata
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/lw_walker.sv
// Latches group expiries, grants the lowest pending group, and follows its list.
module lw_walker #(
  parameter int NUM_GROUPS = 4,
  parameter int NUM_ELEMS  = 64,
  parameter int IDX_W      = 6,
  parameter int GRP_W      = 2
) (
  input  logic                                clk,
  input  logic                                rst,
  input  logic [NUM_GROUPS-1:0]               expire,
  input  logic                                per_we,
  input  logic [GRP_W-1:0]                    per_grp,
  input  logic [NUM_GROUPS-1:0][IDX_W-1:0]    heads,
  output logic [IDX_W-1:0]                    link_raddr,
  input  logic [IDX_W-1:0]                    link_rdata,
  output logic                                leak_vld,
  output logic [IDX_W-1:0]                    leak_idx,
  output logic [GRP_W-1:0]                    leak_grp
);
  localparam int SW = $clog2(NUM_ELEMS + 1);

  logic [NUM_GROUPS-1:0] pend, wr_clr, pend_av, start_clr;
  logic                  busy, any_pend, abort_walk;
  logic [GRP_W-1:0]      act_grp, sel;
  logic [IDX_W-1:0]      cur;
  logic [SW-1:0]         steps;

  assign wr_clr  = per_we ? (NUM_GROUPS'(1) << per_grp) : '0;
  assign pend_av = pend & ~wr_clr;

  always_comb begin
    sel      = '0;
    any_pend = 1'b0;
    for (int g = NUM_GROUPS - 1; g >= 0; g--) begin
      if (pend_av[g]) begin
        sel      = GRP_W'(g);
        any_pend = 1'b1;
      end
    end
  end

  assign start_clr  = (!busy && any_pend) ? (NUM_GROUPS'(1) << sel) : '0;
  assign abort_walk = busy && per_we && (per_grp == act_grp);
  assign link_raddr = cur;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend     <= '0;
      busy     <= 1'b0;
      cur      <= '0;
      act_grp  <= '0;
      steps    <= '0;
      leak_vld <= 1'b0;
      leak_idx <= '0;
      leak_grp <= '0;
    end else begin
      pend     <= (pend & ~start_clr & ~wr_clr) | expire;
      leak_vld <= 1'b0;
      if (!busy) begin
        if (any_pend) begin
          busy    <= 1'b1;
          cur     <= heads[sel];
          act_grp <= sel;
          steps   <= '0;
        end
      end else if (abort_walk) begin
        busy <= 1'b0;
      end else begin
        leak_vld <= 1'b1;
        leak_idx <= cur;
        leak_grp <= act_grp;
        steps    <= steps + 1'b1;
        if (link_rdata == cur || steps == SW'(NUM_ELEMS - 1)) busy <= 1'b0;
        else cur <= link_rdata;
      end
    end
  end

  assert_abort_silences_R7: assert property (@(posedge clk) disable iff (rst)
    abort_walk |=> !leak_vld);
  assert_pulse_from_walk_R4: assert property (@(posedge clk) disable iff (rst)
    leak_vld |-> $past(busy));
  assert_walk_bound_R8: assert property (@(posedge clk) disable iff (rst)
    steps <= SW'(NUM_ELEMS));
  assert_group_steady_R5: assert property (@(posedge clk) disable iff (rst)
    (leak_vld && $past(leak_vld)) |-> (leak_grp == $past(leak_grp)));
endmodule

// File: rtl/leak_walker.sv
module leak_walker #(
  parameter int NUM_GROUPS = 4,
  parameter int NUM_ELEMS  = 64,
  parameter int PERIOD_W   = 24,
  parameter int CLK_NS     = 4,
  localparam int IDX_W  = (NUM_ELEMS > 1) ? $clog2(NUM_ELEMS) : 1,
  localparam int GRP_W  = (NUM_GROUPS > 1) ? $clog2(NUM_GROUPS) : 1,
  localparam int ADDR_W = (IDX_W > GRP_W) ? IDX_W : GRP_W
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic [1:0]          wr_kind,
  input  logic [ADDR_W-1:0]   wr_addr,
  input  logic [PERIOD_W-1:0] wr_data,
  output logic                leak_vld,
  output logic [IDX_W-1:0]    leak_idx,
  output logic [GRP_W-1:0]    leak_grp
);
  import lw_pkg::*;

  logic                             per_we, head_we, link_we;
  logic [GRP_W-1:0]                 wr_grp;
  logic [NUM_GROUPS-1:0]            expire;
  logic [NUM_GROUPS-1:0][IDX_W-1:0] heads;
  logic [IDX_W-1:0]                 link_raddr, link_rdata;
  logic                             unused_bits;

  assign per_we      = wr_en && (wr_kind == WR_PERIOD);
  assign head_we     = wr_en && (wr_kind == WR_HEAD);
  assign link_we     = wr_en && (wr_kind == WR_LINK);
  assign wr_grp      = wr_addr[GRP_W-1:0];
  assign unused_bits = ^{wr_addr, wr_data};

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
    lw_timer #(.PERIOD_W(PERIOD_W), .CLK_NS(CLK_NS)) u_timer (
      .clk    (clk),
      .rst    (rst),
      .per_we (per_we && (wr_grp == GRP_W'(g))),
      .per_val(wr_data),
      .expire (expire[g])
    );

    always_ff @(posedge clk) begin
      if (rst) heads[g] <= '0;
      else if (head_we && (wr_grp == GRP_W'(g))) heads[g] <= wr_data[IDX_W-1:0];
    end
  end

  lw_link_ram #(.DEPTH(NUM_ELEMS), .W(IDX_W)) u_links (
    .clk  (clk),
    .we   (link_we),
    .waddr(wr_addr[IDX_W-1:0]),
    .wdata(wr_data[IDX_W-1:0]),
    .raddr(link_raddr),
    .rdata(link_rdata)
  );

  lw_walker #(.NUM_GROUPS(NUM_GROUPS), .NUM_ELEMS(NUM_ELEMS),
              .IDX_W(IDX_W), .GRP_W(GRP_W)) u_walker (
    .clk       (clk),
    .rst       (rst),
    .expire    (expire),
    .per_we    (per_we),
    .per_grp   (wr_grp),
    .heads     (heads),
    .link_raddr(link_raddr),
    .link_rdata(link_rdata),
    .leak_vld  (leak_vld),
    .leak_idx  (leak_idx),
    .leak_grp  (leak_grp)
  );
endmodule

// File: tb/tb_leak_walker.sv
module tb_leak_walker;
  localparam int CLK_PERIOD = 10;
  localparam int NE = 8;
  localparam int CNS = 4;
  localparam int MAXP = 8192;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_kind = '0;
  logic [2:0]  wr_addr = '0;
  logic [11:0] wr_data = '0;
  logic        leak_vld;
  logic [2:0]  leak_idx;
  logic [1:0]  leak_grp;

  leak_walker #(.NUM_GROUPS(4), .NUM_ELEMS(NE), .PERIOD_W(12), .CLK_NS(CNS)) dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_kind(wr_kind), .wr_addr(wr_addr),
    .wr_data(wr_data), .leak_vld(leak_vld), .leak_idx(leak_idx), .leak_grp(leak_grp)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int cyc = 0;
  int checks = 0;
  int errors = 0;
  int last = 0;
  int np = 0;
  int p_t [MAXP];
  int p_g [MAXP];
  int p_i [MAXP];
  bit done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (!rst && leak_vld && np < MAXP) begin
      p_t[np] = cyc;
      p_g[np] = int'(leak_grp);
      p_i[np] = int'(leak_idx);
      np++;
    end
  end

  task automatic wr(input int kind, input int addr, input int data);
    @(negedge clk);
    wr_en = 1'b1; wr_kind = 2'(kind); wr_addr = 3'(addr); wr_data = 12'(data);
    @(negedge clk);
    wr_en = 1'b0;
    last = cyc;
  endtask

  task automatic wait_until(input int t);
    while (cyc <= t) @(negedge clk);
  endtask

  function automatic int find(input int t);
    for (int i = 0; i < np; i++) if (p_t[i] == t) return i;
    return -1;
  endfunction

  task automatic exp_pulse(input int t, input int g, input int idx, input string req);
    int k;
    k = find(t);
    checks++;
    if (k < 0) begin
      errors++;
      $display("FAIL %s: no pulse at cycle %0d, expected grp %0d idx %0d", req, t, g, idx);
    end else if (p_g[k] != g || p_i[k] != idx) begin
      errors++;
      $display("FAIL %s: cycle %0d got grp %0d idx %0d, expected grp %0d idx %0d",
               req, t, p_g[k], p_i[k], g, idx);
    end
  endtask

  task automatic exp_quiet(input int t0, input int t1, input string req);
    int n;
    n = 0;
    for (int i = 0; i < np; i++) if (p_t[i] >= t0 && p_t[i] <= t1) n++;
    checks++;
    if (n != 0) begin
      errors++;
      $display("FAIL %s: %0d pulses in cycles %0d..%0d, expected 0", req, n, t0, t1);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not finish, got timeout, expected completion");
    summary();
  end

  initial begin
    int e0, ew, n, t, s;
    int eg [4];
    int seq [8];
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset state, no pulse without a period
    checks++;
    if (leak_vld !== 1'b0) begin
      errors++;
      $display("FAIL R1: leak_vld %b after reset, expected 0", leak_vld);
    end
    s = cyc;
    for (int k = 0; k < NE; k++) wr(2, k, k);
    wait_until(s + 40);
    exp_quiet(s, s + 40, "R1");

    // R3 / R9: period sweep on a one-element group
    wr(1, 0, 5);
    for (int p = 5; p <= 40; p++) begin
      wr(0, 0, p);
      e0 = last;
      n = (p + CNS - 1) / CNS;
      wait_until(e0 + 2 * n + 2);
      exp_quiet(e0 + 1, e0 + n + 1, "R3");
      exp_pulse(e0 + n + 2, 0, 5, "R9");
      exp_pulse(e0 + 2 * n + 2, 0, 5, "R3");
      wr(0, 0, 0);
      t = last;
      wait_until(t + 12);
      exp_quiet(t, t + 12, "R2");
    end

    // R4: list order for every length 1..8 on group 1
    for (int len = 1; len <= NE; len++) begin
      for (int k = 0; k < len; k++) seq[k] = (3 * k + 5) % NE;
      for (int k = 0; k < len; k++) wr(2, seq[k], (k == len - 1) ? seq[k] : seq[k + 1]);
      wr(1, 1, seq[0]);
      wr(0, 1, 400);
      e0 = last;
      wait_until(e0 + 100 + 2 + len + 3);
      for (int k = 0; k < len; k++) exp_pulse(e0 + 102 + k, 1, seq[k], "R4");
      exp_quiet(e0 + 102 + len, e0 + 102 + len + 3, "R4");
      wr(0, 1, 0);
    end

    // R5: simultaneous expiry of all four groups
    for (int g = 0; g < 4; g++) begin
      wr(2, 2 * g, 2 * g + 1);
      wr(2, 2 * g + 1, 2 * g + 1);
      wr(1, g, 2 * g);
    end
    for (int g = 3; g >= 0; g--) begin
      wr(0, g, 4 * (10 + 2 * g));
      eg[g] = last;
    end
    t = eg[0] + 10;
    wait_until(t + 13);
    for (int g = 0; g < 4; g++) begin
      exp_pulse(t + 2 + 3 * g, g, 2 * g, "R5");
      exp_pulse(t + 3 + 3 * g, g, 2 * g + 1, "R5");
    end
    for (int g = 0; g < 4; g++) wr(0, g, 0);

    // R6: expiries during a long walk are latched, walks back to back
    for (int k = 0; k < NE; k++) wr(2, k, (k == NE - 1) ? k : k + 1);
    wr(1, 2, 0);
    wr(0, 2, 16);
    e0 = last;
    t = e0 + 4;
    wait_until(t + 2 + 27);
    for (int w = 0; w < 3; w++) begin
      for (int k = 0; k < NE; k++) exp_pulse(t + 2 + 9 * w + k, 2, k, "R6");
      exp_quiet(t + 10 + 9 * w, t + 10 + 9 * w, "R6");
    end
    wr(0, 2, 0);

    // R7: period write to the walking group aborts it
    wr(1, 3, 0);
    wr(0, 3, 40);
    e0 = last;
    while (cyc != e0 + 12) @(negedge clk);
    wr(0, 3, 40);
    ew = last;
    checks++;
    if (ew != e0 + 14) begin
      errors++;
      $display("FAIL R7: abort write at cycle %0d, expected %0d", ew, e0 + 14);
    end
    wait_until(ew + 12 + 1);
    exp_pulse(e0 + 12, 3, 0, "R7");
    exp_pulse(e0 + 13, 3, 1, "R7");
    exp_quiet(ew, ew + 11, "R7");
    exp_pulse(ew + 12, 3, 0, "R7");
    wr(0, 3, 0);

    // R8: a two-element loop is cut after NUM_ELEMS pulses
    wr(2, 4, 6);
    wr(2, 6, 4);
    wr(1, 0, 4);
    wr(0, 0, 400);
    e0 = last;
    wait_until(e0 + 102 + NE + 4);
    for (int k = 0; k < NE; k++) exp_pulse(e0 + 102 + k, 0, (k % 2 == 0) ? 4 : 6, "R8");
    exp_quiet(e0 + 102 + NE, e0 + 102 + NE + 4, "R8");

    // R2: zeroing the period silences the group, including a latched expiry
    wr(0, 0, 0);
    t = last;
    wr(2, 4, 4);
    wr(0, 1, 16);
    wr(1, 1, 0);
    wr(0, 1, 0);
    s = last;
    wait_until(t + 250);
    exp_quiet(t, t + 250, "R2");
    exp_quiet(s, s + 50, "R2");

    summary();
  end
endmodule